// File: doc/BRIEF.md
# DMA Channel Control and Status Register Bank

This block holds the per-channel control and status state of a 64-channel DMA controller. Each channel has four bits: a request enable, an error-interrupt enable, an interrupt-pending flag and an error flag. Each of these bitmaps is read as two 32-bit words. The upper word covers channels 63..32 and the lower word covers channels 31..0. Software changes the bit of one channel by writing that channel number to a byte-wide command register. No read-modify-write of a shared word is needed, so concurrent software agents never race on the same word.

The transfer engine reports three kinds of event, each with a channel number: channel done, interrupt and error. The first error that arrives while the status register is empty is recorded there together with its cause flags. The block also issues one-cycle start pulses toward the engine. It combines pending interrupts and enabled errors into a single interrupt line.

Register access uses a simple word-addressed port. Writes take effect on the clock edge. Reads are combinational from the current address.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset, every bitmap word, the control word and the error status word read zero, `irq` is low and `start_pulse` is low.
- R2: Word addresses 0x02 (channels 63..32) and 0x03 (channels 31..0) read and write the request-enable bitmap. A write of channel number n (data bits 7:0) to 0x0A sets request-enable bit n. A write to 0x0B clears it.
- R3: Words 0x04 (upper) and 0x05 (lower) hold the error-interrupt-enable bitmap. A channel number written to 0x0C sets that channel's bit, and one written to 0x0D clears it.
- R4: An interrupt event (`evt_int_valid`, `evt_int_ch`) sets that channel's pending bit, read at 0x06 (upper) and 0x07 (lower). A channel number written to 0x0E clears the bit. When an event and a clear hit the same bit in the same cycle, the bit ends up set.
- R5: Writes to the interrupt words (0x06/0x07) and error words (0x08/0x09) are write-one-to-clear. Each data bit at one clears the matching flag, and writing all ones empties the word.
- R6: An error event (`evt_err_valid`, `evt_err_ch`) sets that channel's error bit. A channel number written to 0x0F clears it.
- R7: When the status word (0x01) is empty, an error event loads it with bit 31 = 1, the channel in bits 13:8, and `evt_err_flags` masked to bits 15, 14 and 7..0.
- R8: A loaded status word ignores later errors. It returns to zero only when the error bit of the channel it records is cleared.
- R9: `irq` is high exactly when any interrupt-pending bit is set, or any error bit is set whose error-interrupt enable is also set.
- R10: A channel number written to 0x10 drives `start_pulse` high for one cycle after the write edge, with `start_ch` equal to that channel.
- R11: A command value of 64 or above (any of data bits 7:6 set) has no effect on any bitmap and produces no start pulse.
- R12: The control word at 0x00 keeps only bits 31, 3 and 2. All other bits read zero.
- R13: A done event (`evt_done_valid`, `evt_done_ch`) clears that channel's request-enable bit. It takes precedence over a set command in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Word address for read and write |
| reg_wdata | input | 32 | Write data; command registers use bits 7:0 |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| evt_done_valid | input | 1 | Engine reports a channel finished |
| evt_done_ch | input | 6 | Channel of the done event |
| evt_int_valid | input | 1 | Engine raises a channel interrupt |
| evt_int_ch | input | 6 | Channel of the interrupt event |
| evt_err_valid | input | 1 | Engine reports an error |
| evt_err_ch | input | 6 | Channel of the error |
| evt_err_flags | input | 16 | Error cause flags |
| start_pulse | output | 1 | One-cycle start request to the engine |
| start_ch | output | 6 | Channel to start |
| irq | output | 1 | Combined interrupt |

## Verification
Every bitmap bit can be read back through its word view in the cycle after the edge that changes it. A wrong set, clear or mask therefore shows up on the first read that follows. A command decoded from the wrong bits, for example only the low six bits of an out-of-range value, changes a visible bit in the very next cycle. A status word that is overwritten or released too early shows up as a changed value at 0x01 after the second error, or after an unrelated channel's error is cleared. An error in the interrupt combination shows on `irq` with no delay, because the line is driven combinationally from the registered bitmaps.

// File: rtl/dma_chan_regs.sv
module dma_chan_regs #(
  parameter int AW = 5,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          evt_done_valid,
  input  logic [5:0]    evt_done_ch,
  input  logic          evt_int_valid,
  input  logic [5:0]    evt_int_ch,
  input  logic          evt_err_valid,
  input  logic [5:0]    evt_err_ch,
  input  logic [15:0]   evt_err_flags,
  output logic          start_pulse,
  output logic [5:0]    start_ch,
  output logic          irq
);
  localparam int NCH = 2 * DW;
  localparam int CW  = $clog2(NCH);
  localparam logic [15:0] FLAG_MASK = 16'hC0FF;
  localparam logic [DW-1:0] CTRL_MASK = DW'(32'h8000_000C);

  localparam logic [AW-1:0] A_CTRL = AW'(5'h00), A_STAT = AW'(5'h01),
    A_REQ_H = AW'(5'h02), A_REQ_L = AW'(5'h03), A_EIE_H = AW'(5'h04), A_EIE_L = AW'(5'h05),
    A_INT_H = AW'(5'h06), A_INT_L = AW'(5'h07), A_ERR_H = AW'(5'h08), A_ERR_L = AW'(5'h09),
    A_SREQ = AW'(5'h0A), A_CREQ = AW'(5'h0B), A_SEIE = AW'(5'h0C), A_CEIE = AW'(5'h0D),
    A_CINT = AW'(5'h0E), A_CERR = AW'(5'h0F), A_START = AW'(5'h10);

  logic [NCH-1:0] reqen_q, eie_q, int_q, err_q;
  logic [NCH-1:0] reqen_d, eie_d, int_d, err_d;
  logic [DW-1:0]  ctrl_q, stat_q, stat_d;
  logic           cmd_ok;
  logic [CW-1:0]  cmd_ch;
  logic [NCH-1:0] cmd_mask;
  logic           wr_start;

  assign cmd_ok   = (reg_wdata[7:CW] == '0);
  assign cmd_ch   = reg_wdata[CW-1:0];
  assign cmd_mask = cmd_ok ? (NCH'(1) << cmd_ch) : '0;
  assign wr_start = reg_wr && (reg_addr == A_START) && cmd_ok;

  always_comb begin
    reqen_d = reqen_q;
    eie_d   = eie_q;
    int_d   = int_q;
    err_d   = err_q;
    if (reg_wr) begin
      case (reg_addr)
        A_REQ_H: reqen_d[NCH-1:DW] = reg_wdata;
        A_REQ_L: reqen_d[DW-1:0]   = reg_wdata;
        A_SREQ:  reqen_d = reqen_q | cmd_mask;
        A_CREQ:  reqen_d = reqen_q & ~cmd_mask;
        A_EIE_H: eie_d[NCH-1:DW] = reg_wdata;
        A_EIE_L: eie_d[DW-1:0]   = reg_wdata;
        A_SEIE:  eie_d = eie_q | cmd_mask;
        A_CEIE:  eie_d = eie_q & ~cmd_mask;
        A_INT_H: int_d[NCH-1:DW] = int_q[NCH-1:DW] & ~reg_wdata;
        A_INT_L: int_d[DW-1:0]   = int_q[DW-1:0] & ~reg_wdata;
        A_CINT:  int_d = int_q & ~cmd_mask;
        A_ERR_H: err_d[NCH-1:DW] = err_q[NCH-1:DW] & ~reg_wdata;
        A_ERR_L: err_d[DW-1:0]   = err_q[DW-1:0] & ~reg_wdata;
        A_CERR:  err_d = err_q & ~cmd_mask;
        default: ;
      endcase
    end
    if (evt_done_valid) reqen_d[evt_done_ch] = 1'b0;
    if (evt_int_valid)  int_d[evt_int_ch]    = 1'b1;
    if (evt_err_valid)  err_d[evt_err_ch]    = 1'b1;
  end

  always_comb begin
    stat_d = stat_q;
    if (stat_q[31] && !err_d[stat_q[13:8]]) stat_d = '0;
    if (evt_err_valid && !stat_d[31]) begin
      stat_d = '0;
      stat_d[31] = 1'b1;
      stat_d[15:0] = evt_err_flags & FLAG_MASK;
      stat_d[13:8] = evt_err_ch;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reqen_q     <= '0;
      eie_q       <= '0;
      int_q       <= '0;
      err_q       <= '0;
      ctrl_q      <= '0;
      stat_q      <= '0;
      start_pulse <= 1'b0;
      start_ch    <= '0;
    end else begin
      reqen_q     <= reqen_d;
      eie_q       <= eie_d;
      int_q       <= int_d;
      err_q       <= err_d;
      stat_q      <= stat_d;
      start_pulse <= wr_start;
      if (wr_start) start_ch <= cmd_ch;
      if (reg_wr && reg_addr == A_CTRL) ctrl_q <= reg_wdata & CTRL_MASK;
    end
  end

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = ctrl_q;
      A_STAT:  reg_rdata = stat_q;
      A_REQ_H: reg_rdata = reqen_q[NCH-1:DW];
      A_REQ_L: reg_rdata = reqen_q[DW-1:0];
      A_EIE_H: reg_rdata = eie_q[NCH-1:DW];
      A_EIE_L: reg_rdata = eie_q[DW-1:0];
      A_INT_H: reg_rdata = int_q[NCH-1:DW];
      A_INT_L: reg_rdata = int_q[DW-1:0];
      A_ERR_H: reg_rdata = err_q[NCH-1:DW];
      A_ERR_L: reg_rdata = err_q[DW-1:0];
      default: reg_rdata = '0;
    endcase
  end

  assign irq = (|int_q) || (|(err_q & eie_q));

  assert_int_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    evt_int_valid |=> int_q[$past(evt_int_ch)]);

  assert_err_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    evt_err_valid |=> err_q[$past(evt_err_ch)]);

  assert_stat_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stat_q[31] && !reg_wr |=> $stable(stat_q));

  assert_start_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_addr == A_START && reg_wdata[7:CW] == '0
    |=> start_pulse && start_ch == $past(reg_wdata[CW-1:0]));

  assert_range_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && (reg_addr == A_SREQ || reg_addr == A_CREQ) && reg_wdata[7:CW] != '0
    && !evt_done_valid |=> $stable(reqen_q));

  assert_done_clears_R13: assert property (@(posedge clk) disable iff (!rst_n)
    evt_done_valid |=> !reqen_q[$past(evt_done_ch)]);
endmodule

// File: tb/dma_chan_regs_tb.sv
`timescale 1ns/1ps
module dma_chan_regs_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [4:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic evt_done_valid = 1'b0, evt_int_valid = 1'b0, evt_err_valid = 1'b0;
  logic [5:0] evt_done_ch = '0, evt_int_ch = '0, evt_err_ch = '0;
  logic [15:0] evt_err_flags = '0;
  logic start_pulse, irq;
  logic [5:0] start_ch;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  dma_chan_regs u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .evt_done_valid(evt_done_valid), .evt_done_ch(evt_done_ch),
    .evt_int_valid(evt_int_valid), .evt_int_ch(evt_int_ch),
    .evt_err_valid(evt_err_valid), .evt_err_ch(evt_err_ch),
    .evt_err_flags(evt_err_flags),
    .start_pulse(start_pulse), .start_ch(start_ch), .irq(irq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(string req, logic [4:0] a, logic [31:0] exp);
    reg_addr = a;
    #1;
    chk(req, reg_rdata, exp);
  endtask

  task automatic ev_int(logic [5:0] c);
    @(negedge clk); evt_int_valid = 1'b1; evt_int_ch = c;
    @(negedge clk); evt_int_valid = 1'b0;
  endtask

  task automatic ev_err(logic [5:0] c, logic [15:0] f);
    @(negedge clk); evt_err_valid = 1'b1; evt_err_ch = c; evt_err_flags = f;
    @(negedge clk); evt_err_valid = 1'b0;
  endtask

  task automatic t_reset;
    for (int a = 0; a <= 9; a++) rd_chk("R1 word", 5'(a), 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 start", {31'b0, start_pulse}, 32'h0);
  endtask

  task automatic t_reqen;
    wr(5'h0A, 32'd5); wr(5'h0A, 32'd40);
    rd_chk("R2 lo", 5'h03, 32'h0000_0020);
    rd_chk("R2 hi", 5'h02, 32'h0000_0100);
    wr(5'h0B, 32'd5);
    rd_chk("R2 clr", 5'h03, 32'h0);
    wr(5'h03, 32'hA5);
    rd_chk("R2 word", 5'h03, 32'hA5);
    wr(5'h03, 32'h0); wr(5'h02, 32'h0);
  endtask

  task automatic t_eie;
    wr(5'h0C, 32'd63);
    rd_chk("R3 set", 5'h04, 32'h8000_0000);
    wr(5'h0D, 32'd63);
    rd_chk("R3 clr", 5'h04, 32'h0);
  endtask

  task automatic t_int;
    ev_int(6'd3);
    rd_chk("R4 set", 5'h07, 32'h8);
    chk("R9 irq int", {31'b0, irq}, 32'h1);
    wr(5'h0E, 32'd3);
    rd_chk("R4 clr", 5'h07, 32'h0);
    chk("R9 irq off", {31'b0, irq}, 32'h0);
    @(negedge clk);
    evt_int_valid = 1'b1; evt_int_ch = 6'd7;
    reg_wr = 1'b1; reg_addr = 5'h0E; reg_wdata = 32'd7;
    @(negedge clk);
    evt_int_valid = 1'b0; reg_wr = 1'b0;
    rd_chk("R4 event wins", 5'h07, 32'h80);
    wr(5'h0E, 32'd7);
  endtask

  task automatic t_w1c;
    ev_int(6'd0); ev_int(6'd1); ev_int(6'd33);
    wr(5'h07, 32'h1);
    rd_chk("R5 partial", 5'h07, 32'h2);
    wr(5'h07, 32'hFFFF_FFFF);
    rd_chk("R5 lo all", 5'h07, 32'h0);
    rd_chk("R5 hi kept", 5'h06, 32'h2);
    wr(5'h06, 32'hFFFF_FFFF);
    rd_chk("R5 hi all", 5'h06, 32'h0);
  endtask

  task automatic t_err;
    ev_err(6'd34, 16'hFFFF);
    rd_chk("R6 set", 5'h08, 32'h4);
    rd_chk("R7 capture", 5'h01, 32'h8000_E2FF);
    chk("R9 err masked", {31'b0, irq}, 32'h0);
    wr(5'h0C, 32'd34);
    chk("R9 err enabled", {31'b0, irq}, 32'h1);
    ev_err(6'd2, 16'h0001);
    rd_chk("R6 second", 5'h09, 32'h4);
    rd_chk("R8 kept", 5'h01, 32'h8000_E2FF);
    wr(5'h0F, 32'd2);
    rd_chk("R6 clr", 5'h09, 32'h0);
    rd_chk("R8 other clr", 5'h01, 32'h8000_E2FF);
    wr(5'h0F, 32'd34);
    rd_chk("R8 released", 5'h01, 32'h0);
    chk("R9 irq gone", {31'b0, irq}, 32'h0);
    ev_err(6'd9, 16'h0010);
    rd_chk("R7 recapture", 5'h01, 32'h8000_0910);
    wr(5'h09, 32'hFFFF_FFFF);
    rd_chk("R5 err w1c", 5'h09, 32'h0);
    rd_chk("R8 w1c release", 5'h01, 32'h0);
    wr(5'h0D, 32'd34);
  endtask

  task automatic t_start;
    wr(5'h10, 32'd12);
    chk("R10 pulse", {31'b0, start_pulse}, 32'h1);
    chk("R10 chan", {26'b0, start_ch}, 32'd12);
    @(negedge clk);
    chk("R10 one cycle", {31'b0, start_pulse}, 32'h0);
  endtask

  task automatic t_range;
    wr(5'h0A, 32'd64); wr(5'h0A, 32'd200);
    rd_chk("R11 req lo", 5'h03, 32'h0);
    rd_chk("R11 req hi", 5'h02, 32'h0);
    ev_int(6'd0);
    wr(5'h0E, 32'd64);
    rd_chk("R11 int kept", 5'h07, 32'h1);
    wr(5'h10, 32'd70);
    chk("R11 no start", {31'b0, start_pulse}, 32'h0);
    wr(5'h0E, 32'd0);
  endtask

  task automatic t_ctrl;
    wr(5'h00, 32'hFFFF_FFFF);
    rd_chk("R12 ctrl", 5'h00, 32'h8000_000C);
  endtask

  task automatic t_done;
    wr(5'h0A, 32'd20);
    rd_chk("R13 pre", 5'h03, 32'h0010_0000);
    @(negedge clk); evt_done_valid = 1'b1; evt_done_ch = 6'd20;
    @(negedge clk); evt_done_valid = 1'b0;
    rd_chk("R13 cleared", 5'h03, 32'h0);
    @(negedge clk);
    evt_done_valid = 1'b1; evt_done_ch = 6'd21;
    reg_wr = 1'b1; reg_addr = 5'h0A; reg_wdata = 32'd21;
    @(negedge clk);
    evt_done_valid = 1'b0; reg_wr = 1'b0;
    rd_chk("R13 wins", 5'h03, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset; t_reqen; t_eie; t_int; t_w1c; t_err; t_start; t_range; t_ctrl; t_done;
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule